// File: doc/BRIEF.md
# Condition and overflow flag updater

This block sits after the integer adder and multiplier of a 64-bit core and turns their side indications into architectural flag state. For each completed operation it is given the 64-bit result, the signed-overflow and carry-out bits, the record and overflow-enable instruction bits, a carry-write flag and the current 32/64-bit mode. It keeps the summary-overflow (SO), overflow (OV) and carry (CA) bits as registers, and it produces the 4-bit condition field for field 0 together with a one-cycle write enable.

Updates are offered with `upd_valid`. The block accepts every offered update in the cycle it is presented, so there is no ready pin and no back-pressure: the producer may offer an update on every cycle. The condition field and the XER bits reflect an update on the clock edge that samples it. Arithmetic is not done here, and the other condition fields and the byte-count part of the XER are outside this block.

Top module: `flag_updater`

## Requirements
- R1: After reset `xer_so`, `xer_ov`, `xer_ca` and `cr0_we` are all 0.
- R2: With `mode64`=1 the whole 64-bit result is taken as a signed number and compared with zero.
- R3: With `mode64`=0 only result bits [31:0] (LSB-0 numbering), read as a signed 32-bit number, are compared with zero; bits [63:32] have no effect on the field.
- R4: The field is `cr0_val` = {LT, GT, EQ, SO} in bits [3:0]: LT=bit 3 for a negative value, GT=bit 2 for positive, EQ=bit 1 for zero, exactly one of them set; it is written (`cr0_we`=1) on the edge after an accepted update with `rec_en`=1, and `cr0_we` is 0 otherwise.
- R5: An accepted update with `ovf_en`=1 sets OV to `ovf_in` and SO to the old SO ORed with `ovf_in`; with `ovf_en`=0 OV and SO are kept.
- R6: When `rec_en`, `ovf_en` and `ovf_in` are all 1, bit 0 of the written field is 1 even when SO was 0 before that update.
- R7: An accepted update with `ca_wr`=1 sets CA to `carry_in`; with `ca_wr`=0 CA is kept.
- R8: With `so_is_ovf`=1 (the recording form of add-immediate-carrying), bit 0 of the field is `ovf_in` itself and not the SO value.
- R9: A record-only update (`rec_en`=1, `ovf_en`=0, `so_is_ovf`=0) puts the current SO into bit 0 and leaves OV and SO unchanged.
- R10: While `upd_valid`=0 no flag changes and `cr0_we` is 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | An operation's flags are offered this cycle |
| result | input | 64 | Operation result |
| ovf_in | input | 1 | Signed overflow of the operation |
| carry_in | input | 1 | Carry-out of the operation |
| rec_en | input | 1 | Record bit: write condition field 0 |
| ovf_en | input | 1 | Overflow-enable bit: write OV and SO |
| ca_wr | input | 1 | Operation writes CA |
| so_is_ovf | input | 1 | Field bit 0 takes `ovf_in` directly |
| mode64 | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| cr0_val | output | 4 | Field value {LT, GT, EQ, SO} |
| cr0_we | output | 1 | Field write enable, one cycle |
| xer_so | output | 1 | Summary overflow |
| xer_ov | output | 1 | Overflow |
| xer_ca | output | 1 | Carry |

## Verification
The recording of the field and the overflow update fall in the same cycle when `rec_en` and `ovf_en` are both set: the field's SO bit must then see the overflow of that very update rather than the registered SO. The bench provokes this directly with SO cleared and an overflowing update, and then throughout a random stream where both bits are set often, judging the field bit against a model that computes the new SO before forming the field. The carry write is mixed into the same updates so all three XER bits move together.

// File: rtl/flag_updater_pkg.sv
package flag_updater_pkg;
  parameter int unsigned WORD_W   = 64;
  parameter int unsigned NARROW_W = 32;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } sign_cls_t;
endpackage

// File: rtl/flag_sign_class.sv
module flag_sign_class
  import flag_updater_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned HALF_W = NARROW_W
) (
  input  logic [DATA_W-1:0] value,
  input  logic              wide,
  output sign_cls_t         cls
);
  localparam int unsigned HI_W = DATA_W - HALF_W;

  logic half_neg, half_zero, hi_zero, sel_neg, sel_zero;

  assign half_neg  = value[HALF_W-1];
  assign half_zero = (value[HALF_W-1:0] == '0);
  assign hi_zero   = (value[DATA_W-1:HALF_W] == {HI_W{1'b0}});

  always_comb begin
    if (wide) begin
      sel_neg  = value[DATA_W-1];
      sel_zero = half_zero && hi_zero;
    end else begin
      sel_neg  = half_neg;
      sel_zero = half_zero;
    end
    cls.lt = sel_neg;
    cls.eq = sel_zero;
    cls.gt = !sel_neg && !sel_zero;
  end

  always_comb begin
    assert ($countones({cls.lt, cls.gt, cls.eq}) == 1)
      else $error("AST_ONE_CLASS"); // R4
  end
endmodule

// File: rtl/flag_xer_regs.sv
module flag_xer_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic oe,
  input  logic ovf,
  input  logic ca_we,
  input  logic carry,
  output logic so_q,
  output logic ov_q,
  output logic ca_q,
  output logic so_next
);
  assign so_next = oe ? (so_q | ovf) : so_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so_q <= 1'b0;
      ov_q <= 1'b0;
      ca_q <= 1'b0;
    end else if (upd) begin
      so_q <= so_next;
      if (oe)    ov_q <= ovf;
      if (ca_we) ca_q <= carry;
    end
  end

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    so_q |=> so_q); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && oe && !ovf) |=> !ov_q); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(so_q) && $stable(ov_q) && $stable(ca_q))); // R10
  AST_CA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ca_we) |=> $stable(ca_q)); // R7
endmodule

// File: rtl/flag_cr0_reg.sv
module flag_cr0_reg
  import flag_updater_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd,
  input  logic      rec,
  input  sign_cls_t cls,
  input  logic      so_bit,
  output cr_field_t field_q,
  output logic      we_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= upd && rec;
      if (upd && rec) field_q <= '{lt: cls.lt, gt: cls.gt, eq: cls.eq, so: so_bit};
    end
  end

  AST_WE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && rec) |=> we_q); // R4
  AST_WE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !we_q); // R10
  AST_FIELD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ($countones({field_q.lt, field_q.gt, field_q.eq}) == 1)); // R4
endmodule

// File: rtl/flag_updater.sv
module flag_updater
  import flag_updater_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned HALF_W = NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [DATA_W-1:0] result,
  input  logic              ovf_in,
  input  logic              carry_in,
  input  logic              rec_en,
  input  logic              ovf_en,
  input  logic              ca_wr,
  input  logic              so_is_ovf,
  input  logic              mode64,
  output logic [3:0]        cr0_val,
  output logic              cr0_we,
  output logic              xer_so,
  output logic              xer_ov,
  output logic              xer_ca
);
  sign_cls_t cls;
  cr_field_t field_q;
  logic      so_next, so_bit;

  flag_sign_class #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cls (
    .value (result),
    .wide  (mode64),
    .cls   (cls)
  );

  flag_xer_regs u_xer (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd_valid),
    .oe      (ovf_en),
    .ovf     (ovf_in),
    .ca_we   (ca_wr),
    .carry   (carry_in),
    .so_q    (xer_so),
    .ov_q    (xer_ov),
    .ca_q    (xer_ca),
    .so_next (so_next)
  );

  // the field sees the SO this same update produces, not the registered one
  assign so_bit = so_is_ovf ? ovf_in : so_next;

  flag_cr0_reg u_cr0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (upd_valid),
    .rec     (rec_en),
    .cls     (cls),
    .so_bit  (so_bit),
    .field_q (field_q),
    .we_q    (cr0_we)
  );

  assign cr0_val = field_q;

  AST_FRESH_SO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && rec_en && ovf_en && ovf_in && !so_is_ovf) |=> cr0_val[0]); // R6
  AST_DIRECT_SO: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && rec_en && so_is_ovf) |=> (cr0_val[0] == $past(ovf_in))); // R8
endmodule

// File: tb/tb_flag_updater.sv
module tb_flag_updater;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid, ovf_in, carry_in, rec_en, ovf_en, ca_wr, so_is_ovf, mode64;
  logic [63:0] result;
  logic [3:0]  cr0_val;
  logic        cr0_we, xer_so, xer_ov, xer_ca;

  int checks = 0;
  int failures = 0;
  logic m_so, m_ov, m_ca;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_updater dut (.*);

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [2:0] classify(input logic [63:0] v, input logic wide);
    logic neg, zero;
    neg  = wide ? v[63] : v[31];
    zero = wide ? (v == 64'd0) : (v[31:0] == 32'd0);
    return {neg, !neg && !zero, zero};
  endfunction

  // one offered (or idle) cycle; model and check after the edge
  task automatic step(input string tag, input logic vld, input logic [63:0] res,
                      input logic ovf, input logic cy, input logic rc, input logic oe,
                      input logic cw, input logic sov, input logic wide);
    logic [3:0] exp_f;
    logic       exp_we, so_n;
    @(negedge clk);
    upd_valid = vld; result = res; ovf_in = ovf; carry_in = cy; rec_en = rc;
    ovf_en = oe; ca_wr = cw; so_is_ovf = sov; mode64 = wide;
    so_n   = oe ? (m_so | ovf) : m_so;
    exp_we = vld && rc;
    exp_f  = {classify(res, wide), sov ? ovf : so_n};
    if (vld) begin
      m_so = so_n;
      if (oe) m_ov = ovf;
      if (cw) m_ca = cy;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if (cr0_we !== exp_we || (exp_we && cr0_val !== exp_f) ||
        xer_so !== m_so || xer_ov !== m_ov || xer_ca !== m_ca) begin
      failures++;
      $display("FAIL %s got we=%b f=%b so=%b ov=%b ca=%b exp we=%b f=%b so=%b ov=%b ca=%b",
               tag, cr0_we, cr0_val, xer_so, xer_ov, xer_ca, exp_we, exp_f, m_so, m_ov, m_ca);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; upd_valid = 0; result = '0; ovf_in = 0; carry_in = 0;
    rec_en = 0; ovf_en = 0; ca_wr = 0; so_is_ovf = 0; mode64 = 1;
    m_so = 0; m_ov = 0; m_ca = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    checks++;
    if ({xer_so, xer_ov, xer_ca, cr0_we} !== 4'b0) begin
      failures++;
      $display("FAIL R1 got %b exp 0000", {xer_so, xer_ov, xer_ca, cr0_we});
    end
    // R2: full-width compare
    step("R2 zero64",  1, 64'd0,                  0,0,1,0,0,0,1);
    step("R2 neg64",   1, 64'h8000_0000_0000_0000,0,0,1,0,0,0,1);
    step("R2 pos64",   1, 64'h0000_0000_8000_0000,0,0,1,0,0,0,1);
    // R3: narrow compare ignores upper half
    step("R3 hi-only", 1, 64'hFFFF_FFFF_0000_0000,0,0,1,0,0,0,0);
    step("R3 neg32",   1, 64'h0000_0000_8000_0000,0,0,1,0,0,0,0);
    step("R3 pos32",   1, 64'h8000_0000_0000_0001,0,0,1,0,0,0,0);
    // R6 and R5: overflow with record while SO was 0
    step("R6 fresh so",1, 64'd5,                  1,0,1,1,0,0,1);
    // R5: OE without overflow clears OV, SO sticky
    step("R5 ov clr",  1, 64'd7,                  0,0,0,1,0,0,1);
    // R9: record-only keeps flags, uses current SO (1)
    step("R9 rec only",1, 64'd0,                  0,0,1,0,0,0,1);
    // R10: idle cycle with busy inputs
    step("R10 idle",   0, 64'hDEAD,               1,1,1,1,1,0,1);
    // R7: carry write and keep
    step("R7 ca set",  1, 64'd1,                  0,1,0,0,1,0,1);
    step("R7 ca keep", 1, 64'd1,                  0,0,0,0,0,0,1);
    // R8: field bit 0 is ovf_in itself
    step("R8 direct0", 1, 64'd3,                  0,0,1,0,1,1,1);
    step("R8 direct1", 1, 64'hFFFF_FFFF_FFFF_FFFF,1,1,1,0,1,1,0);
    // R4: random mix of all functions
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) r = 64'd0;
      if ($urandom_range(0, 7) == 0) r[31:0] = 32'd0;
      step("R4 R5 random", $urandom_range(0, 4) != 0, r, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 5) == 0,
           1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule